// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind the serial front-end of a serial memory and handles the data phase of the two write-type commands: the array write and the status write. As bytes arrive, it places them into a one-page staging buffer. It then watches for the chip-select rising event to decide whether the operation goes ahead. A commit happens only when chip select rises in the short gap after a complete byte and before the next serial clock rising edge. A rise anywhere else discards the command.

Once committed, the block holds a busy flag for a fixed number of system-clock cycles. In the first cycles of that interval it drains the staged bytes into the array, one per cycle, and skips any slot whose address is reported as protected. A status write instead produces a single status-register strobe. In the last busy cycle the block pulses a request to clear the write-enable latch. The serial front-end supplies pulses for bit clocks, completed bytes, command decode and chip-select rise, all in the system clock domain.

Top module: `page_commit_ctrl`

## Requirements
- R1: Staged bytes land in the page slot given by the low 5 address bits. The slot starts at the start address and advances by one per byte, wrapping modulo 32. The upper address bits stay fixed, so the 33rd and later bytes overwrite earlier slots.
- R2: A chip-select rise that comes after a completed byte (byte_vld_i) and before the next sck_rise_i commits the command. busy_o goes high in the cycle after the rise and stays high for exactly BUSY_CYC cycles.
- R3: A chip-select rise after a bit clock of an unfinished byte cancels the write. No busy interval and no array strobe follow.
- R4: A status write commits only when chip select rises between completion of its 8-bit data byte and the next bit clock. Any later rise cancels it. A committed status write gives exactly one sr_we_o, in the first busy cycle, carrying the received byte and no array strobe.
- R5: A write or status-write command seen while wen_i is 0 is discarded and produces no busy interval.
- R6: wen_clr_o pulses exactly once per committed operation, in its last busy cycle, and never for a cancelled one.
- R7: While busy_o is high, new commands, bytes, bit clocks and chip-select rises change nothing. The running interval keeps its full length and no second interval starts.
- R8: When lockout_i is high on the commit cycle, the operation does not start.
- R9: A staged byte whose array address has prot_i high is not strobed. The other staged bytes of the same page are still written.
- R10: Staged slot k is written in busy cycle k (counting from 0), in ascending slot order. arr_addr_o carries the fixed upper bits above slot k, and slots never loaded are skipped.
- R11: After reset, busy_o, arr_we_o, sr_we_o and wen_clr_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_cmd_i | input | 1 | Pulse: array write command and address decoded |
| sr_cmd_i | input | 1 | Pulse: status write command decoded |
| addr_i | input | ADDR_W | Start address, valid with wr_cmd_i |
| sck_rise_i | input | 1 | Pulse per serial clock rising edge |
| byte_vld_i | input | 1 | Pulse: last bit of a data byte sampled |
| byte_i | input | DATA_W | Completed data byte, valid with byte_vld_i |
| cs_rise_i | input | 1 | Pulse: chip select deasserted |
| wen_i | input | 1 | Write-enable latch value |
| lockout_i | input | 1 | Low-supply lockout, blocks a commit |
| prot_i | input | 1 | Protection flag for the current arr_addr_o |
| busy_o | output | 1 | Write interval in progress |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| sr_we_o | output | 1 | Status register write strobe |
| sr_data_o | output | DATA_W | Status register write data |
| wen_clr_o | output | 1 | Request to clear the write-enable latch |

## Verification
A chip-select pulse sampled on clock edge t makes busy_o visible from edge t+1 through edge t+BUSY_CYC. The write for slot k falls in the k-th of those busy cycles, counted from 0. sr_we_o comes in the first busy cycle and wen_clr_o in the last. A monitor samples on the falling edge and records, for every strobe, the slot, the data, the upper address bits and the busy-cycle index. After each transaction the bench waits longer than the full interval and compares that record, along with the counts of busy cycles, clear pulses and strobes, against page contents it computes from the start slot, the byte count and the protection threshold. For cancelled or ignored commands, the same counts must stay at zero.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_ARMED,
    PH_DEAD
  } ph_e;
endpackage

// File: rtl/pwc_commit_fsm.sv
`timescale 1ns/1ps
module pwc_commit_fsm
  import pwc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_cmd_i,
  input  logic sr_cmd_i,
  input  logic wen_i,
  input  logic busy_i,
  input  logic byte_vld_i,
  input  logic sck_rise_i,
  input  logic cs_rise_i,
  input  logic lockout_i,
  output logic start_o,
  output logic load_o,
  output logic commit_o,
  output logic is_sr_o
);
  ph_e  ph_q, ph_d;
  logic sr_q;

  assign start_o = (ph_q == PH_IDLE) && !busy_i && wen_i && (wr_cmd_i || sr_cmd_i);
  assign load_o  = (ph_q == PH_LOAD) && byte_vld_i && !cs_rise_i;
  assign is_sr_o = sr_q;

  always_comb begin
    ph_d     = ph_q;
    commit_o = 1'b0;
    unique case (ph_q)
      PH_IDLE:  if (start_o) ph_d = PH_LOAD;
      PH_LOAD: begin
        if (cs_rise_i)       ph_d = PH_IDLE;
        else if (byte_vld_i) ph_d = PH_ARMED;
      end
      PH_ARMED: begin
        // commit window: byte complete, next bit clock not yet seen
        if (cs_rise_i) begin
          ph_d     = PH_IDLE;
          commit_o = !lockout_i;
        end else if (sck_rise_i) begin
          ph_d = sr_q ? PH_DEAD : PH_LOAD;
        end
      end
      PH_DEAD:  if (cs_rise_i) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE;
      sr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (start_o) sr_q <= sr_cmd_i;
    end
  end
endmodule

// File: rtl/pwc_page_buf.sv
`timescale 1ns/1ps
module pwc_page_buf #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic                          load_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_vld_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] upper_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int UP_W  = ADDR_W - OFS_W;

  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [OFS_W-1:0]      ptr_q;
  logic [UP_W-1:0]       up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < PAGE_BYTES; s++) data_q[s] <= '0;
      vld_q <= '0;
      ptr_q <= '0;
      up_q  <= '0;
    end else if (start_i) begin
      vld_q <= '0;
      ptr_q <= base_i[OFS_W-1:0];
      up_q  <= base_i[ADDR_W-1:OFS_W];
    end else if (load_i) begin
      data_q[ptr_q] <= data_i;
      vld_q[ptr_q]  <= 1'b1;
      ptr_q         <= ptr_q + 1'b1; // wraps inside the page
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign upper_o   = up_q;
endmodule

// File: rtl/pwc_busy_timer.sv
`timescale 1ns/1ps
module pwc_busy_timer #(
  parameter int BUSY_CYC = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        commit_i,
  output logic                        busy_o,
  output logic                        last_o,
  output logic [$clog2(BUSY_CYC)-1:0] cnt_o
);
  localparam int CNT_W = $clog2(BUSY_CYC);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BUSY_CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_END) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (commit_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_END);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/page_commit_ctrl.sv
`timescale 1ns/1ps
module page_commit_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int BUSY_CYC   = 64  // must be >= PAGE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              sr_cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sck_rise_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cs_rise_i,
  input  logic              wen_i,
  input  logic              lockout_i,
  input  logic              prot_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              sr_we_o,
  output logic [DATA_W-1:0] sr_data_o,
  output logic              wen_clr_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int UP_W  = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(BUSY_CYC);

  logic              start, load, commit, is_sr, busy, last;
  logic [CNT_W-1:0]  cnt;
  logic [OFS_W-1:0]  slot;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld;
  logic [UP_W-1:0]   upper;
  logic [ADDR_W-1:0] base;
  logic              in_page;

  assign base = sr_cmd_i ? '0 : addr_i;

  pwc_commit_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cmd_i   (wr_cmd_i),
    .sr_cmd_i   (sr_cmd_i),
    .wen_i      (wen_i),
    .busy_i     (busy),
    .byte_vld_i (byte_vld_i),
    .sck_rise_i (sck_rise_i),
    .cs_rise_i  (cs_rise_i),
    .lockout_i  (lockout_i),
    .start_o    (start),
    .load_o     (load),
    .commit_o   (commit),
    .is_sr_o    (is_sr)
  );

  pwc_page_buf #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .base_i    (base),
    .load_i    (load),
    .data_i    (byte_i),
    .rd_idx_i  (slot),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .upper_o   (upper)
  );

  pwc_busy_timer #(
    .BUSY_CYC (BUSY_CYC)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .busy_o   (busy),
    .last_o   (last),
    .cnt_o    (cnt)
  );

  // drain: busy cycle k serves slot k
  assign slot    = cnt[OFS_W-1:0];
  assign in_page = int'(cnt) < PAGE_BYTES;

  assign busy_o     = busy;
  assign arr_we_o   = busy && !is_sr && in_page && rd_vld && !prot_i;
  assign arr_addr_o = {upper, slot};
  assign arr_data_o = rd_data;
  assign sr_we_o    = busy && is_sr && (cnt == '0);
  assign sr_data_o  = rd_data;
  assign wen_clr_o  = last;
endmodule

// File: rtl/pwc_checker.sv
`timescale 1ns/1ps
module pwc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_rise_i,
  input logic lockout_i,
  input logic busy_o,
  input logic arr_we_o,
  input logic sr_we_o,
  input logic wen_clr_o
);
  // R2
  busy_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i));
  // R8
  lockout_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(lockout_i));
  // R7
  busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wen_clr_o) |=> busy_o);
  // R6
  clr_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |=> !busy_o);
  // R6
  busy_end_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(wen_clr_o));
  // R4
  we_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_we_o && sr_we_o));
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(arr_we_o || sr_we_o || wen_clr_o));
endmodule

bind page_commit_ctrl pwc_checker i_pwc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_rise_i (cs_rise_i),
  .lockout_i (lockout_i),
  .busy_o    (busy_o),
  .arr_we_o  (arr_we_o),
  .sr_we_o   (sr_we_o),
  .wen_clr_o (wen_clr_o)
);

// File: tb/test_page_commit_ctrl.sv
`timescale 1ns/1ps
module test_page_commit_ctrl;
  localparam int BUSY = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_cmd = 0, sr_cmd = 0, sck_rise = 0, byte_vld = 0, cs_rise = 0;
  logic       wen = 1'b1, lockout = 1'b0, prot_on = 1'b0;
  logic [4:0] prot_from = '0;
  logic [11:0] addr = '0;
  logic [7:0] byte_d = '0;
  logic       prot, busy, arr_we, sr_we, wen_clr;
  logic [11:0] arr_addr;
  logic [7:0] arr_data, sr_data;

  int nchk = 0, nerr = 0;
  int n_we, n_sr, n_busy, n_clr;
  bit lg_v [32];
  logic [7:0] lg_d [32];
  int lg_t [32];
  logic [6:0] lg_up;
  logic [7:0] lg_sr;
  bit ex_v [32];
  logic [7:0] ex_d [32];

  always #4 clk = ~clk;

  assign prot = prot_on && (arr_addr[4:0] >= prot_from);

  page_commit_ctrl #(.BUSY_CYC(BUSY)) i_page_commit_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_cmd_i(wr_cmd), .sr_cmd_i(sr_cmd), .addr_i(addr),
    .sck_rise_i(sck_rise), .byte_vld_i(byte_vld), .byte_i(byte_d), .cs_rise_i(cs_rise),
    .wen_i(wen), .lockout_i(lockout), .prot_i(prot), .busy_o(busy), .arr_we_o(arr_we),
    .arr_addr_o(arr_addr), .arr_data_o(arr_data), .sr_we_o(sr_we), .sr_data_o(sr_data),
    .wen_clr_o(wen_clr)
  );

  always @(negedge clk) begin
    if (arr_we) begin
      lg_v[arr_addr[4:0]] = 1'b1;
      lg_d[arr_addr[4:0]] = arr_data;
      lg_t[arr_addr[4:0]] = n_busy;
      lg_up = arr_addr[11:5];
      n_we++;
    end
    if (sr_we) begin n_sr++; lg_sr = sr_data; end
    if (wen_clr) n_clr++;
    if (busy) n_busy++;
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] dv(input int k, input int seed);
    return 8'((k * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic clear_log();
    for (int s = 0; s < 32; s++) begin
      lg_v[s] = 0; lg_d[s] = '0; lg_t[s] = -1; ex_v[s] = 0; ex_d[s] = '0;
    end
    n_we = 0; n_sr = 0; n_busy = 0; n_clr = 0; lg_up = '0; lg_sr = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_cmd(input bit is_sr, input int a);
    @(negedge clk); wr_cmd = !is_sr; sr_cmd = is_sr; addr = 12'(a);
    @(negedge clk); wr_cmd = 0; sr_cmd = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_rise = 1; byte_vld = (i == 7); byte_d = b;
    end
    @(negedge clk); sck_rise = 0; byte_vld = 0;
  endtask

  task automatic pulse_sck();
    @(negedge clk); sck_rise = 1;
    @(negedge clk); sck_rise = 0;
  endtask

  task automatic pulse_cs();
    @(negedge clk); cs_rise = 1;
    @(negedge clk); cs_rise = 0;
  endtask

  // build expected page: n bytes from slot s0, slots >= pf dropped when pon
  task automatic model_page(input int s0, input int n, input int seed, input bit pon, input int pf);
    for (int k = 0; k < n; k++) begin
      int s = (s0 + k) % 32;
      if (!(pon && s >= pf)) begin ex_v[s] = 1; ex_d[s] = dv(k, seed); end
    end
  endtask

  task automatic check_page(input string req);
    for (int s = 0; s < 32; s++) begin
      chk(req, $sformatf("slot %0d written", s), int'(lg_v[s]), int'(ex_v[s]));
      if (ex_v[s]) begin
        chk(req, $sformatf("slot %0d data", s), int'(lg_d[s]), int'(ex_d[s]));
        chk("R10", $sformatf("slot %0d busy cycle", s), lg_t[s], s);
      end
    end
  endtask

  task automatic do_write(input int a, input int n, input int seed);
    start_cmd(0, a);
    for (int k = 0; k < n; k++) send_byte(dv(k, seed));
    pulse_cs();
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    clear_log();
    step(3);
    // R11 reset state
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "arr_we", int'(arr_we), 0);
    chk("R11", "sr_we/wen_clr", int'(sr_we | wen_clr), 0);
    rst_n = 1'b1;
    step(2);

    // R2 R10 R6 basic commit, 4 bytes at slot 5 upper 0x1D
    clear_log();
    do_write(12'h3A5, 4, 1);
    step(BUSY + 6);
    model_page(5, 4, 1, 0, 0);
    check_page("R2");
    chk("R2", "busy cycles", n_busy, BUSY);
    chk("R6", "wen_clr pulses", n_clr, 1);
    chk("R10", "upper bits", int'(lg_up), 'h1D);
    chk("R2", "strobes", n_we, 4);

    // R1 rollover: 34 bytes from slot 30, upper 0x3F
    clear_log();
    do_write(12'h7FE, 34, 2);
    step(BUSY + 6);
    model_page(30, 34, 2, 0, 0);
    check_page("R1");
    chk("R1", "upper bits", int'(lg_up), 'h3F);
    chk("R1", "strobes", n_we, 32);

    // R3 cancel mid-byte
    clear_log();
    start_cmd(0, 12'h010);
    send_byte(8'h11); send_byte(8'h22);
    pulse_sck();
    pulse_cs();
    step(BUSY + 6);
    chk("R3", "busy cycles", n_busy, 0);
    chk("R3", "strobes", n_we, 0);
    chk("R6", "wen_clr after cancel", n_clr, 0);

    // R5 wen low discards
    clear_log();
    wen = 1'b0;
    do_write(12'h020, 2, 3);
    step(BUSY + 6);
    chk("R5", "busy cycles", n_busy, 0);
    chk("R5", "strobes", n_we, 0);
    wen = 1'b1;

    // R4 status write committed in window
    clear_log();
    start_cmd(1, 0);
    send_byte(8'h8C);
    pulse_cs();
    step(BUSY + 6);
    chk("R4", "sr strobes", n_sr, 1);
    chk("R4", "sr data", int'(lg_sr), 'h8C);
    chk("R4", "array strobes", n_we, 0);
    chk("R4", "busy cycles", n_busy, BUSY);

    // R4 status write with extra bit clock cancels
    clear_log();
    start_cmd(1, 0);
    send_byte(8'h0C);
    pulse_sck();
    pulse_cs();
    step(BUSY + 6);
    chk("R4", "late cs busy", n_busy, 0);
    chk("R4", "late cs sr strobes", n_sr, 0);

    // R4 status write with a second byte cancels
    clear_log();
    start_cmd(1, 0);
    send_byte(8'h04); send_byte(8'h08);
    pulse_cs();
    step(BUSY + 6);
    chk("R4", "two-byte busy", n_busy, 0);

    // R8 lockout at commit
    clear_log();
    lockout = 1'b1;
    do_write(12'h040, 3, 4);
    step(BUSY + 6);
    lockout = 1'b0;
    chk("R8", "busy cycles", n_busy, 0);
    chk("R8", "strobes", n_we, 0);

    // R9 protection of slots 16..31, full page from slot 0
    clear_log();
    prot_on = 1'b1; prot_from = 5'd16;
    do_write(12'h120, 32, 5);
    step(BUSY + 6);
    prot_on = 1'b0;
    model_page(0, 32, 5, 1, 16);
    check_page("R9");
    chk("R9", "strobes", n_we, 16);
    chk("R9", "busy cycles", n_busy, BUSY);

    // R7 traffic during busy is ignored
    clear_log();
    do_write(12'h200, 1, 6);
    step(3);
    start_cmd(0, 12'h205);
    send_byte(8'hAA);
    pulse_cs();
    pulse_sck();
    pulse_cs();
    step(BUSY + 10);
    model_page(0, 1, 6, 0, 0);
    check_page("R7");
    chk("R7", "busy cycles", n_busy, BUSY);
    chk("R7", "wen_clr pulses", n_clr, 1);
    chk("R7", "strobes", n_we, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule